// File: doc/BRIEF.md
# Pixel Phase Recovery from RGB

This block recovers a sampling phase for a 12-bit colour stream (4 bits each of red, green and blue) that arrives with no pixel clock beside it. It runs on a master clock that is a fixed integer multiple of the pixel rate. By default the multiple is four. A free-running divider labels every master-clock edge with a sub-pixel phase. The pixel frequency is therefore known in advance, and only the phase has to be found. The block never tries to follow a frequency mismatch.

A colour transition is seen when any of the 12 input bits differs from the word sampled one master clock earlier. In the first acquisition window the block counts transitions per sub-pixel phase. It then places the coarse sampling phase half a pixel away from the busiest phase. Next it trims an external programmable delay line through a 7-bit binary code. The code starts at mid-scale and moves one step per window toward the quieter neighbouring phase, then freezes. Once frozen, the block resamples the input on the chosen phase and emits each pixel with a one-cycle valid strobe. A synchronous relock input throws the result away and starts over.

Top module: `pixelPhaseRecover`

## Requirements
- R1: After reset, `locked` and `pixValid` are low, `delayCode` is 64 and `samplePhase` is 0. The sub-pixel phase counter reads 0 at the first rising edge after reset is released and advances by one per edge, modulo `PHASES`.
- R2: A transition is a sample in which any single bit or group of bits of `pixIn` differs from the previous sample. It is credited to the phase of the edge at which the changed word is first sampled.
- R3: At the end of the acquisition window, `samplePhase` becomes (p + PHASES/2) mod PHASES, where p is the phase with the most transitions. On a tie, the lowest-numbered phase wins.
- R4: A window closes exactly when `ACQ_TOTAL` transitions have been counted since the last clear. Each per-phase counter is `CNT_W` bits wide and saturates instead of wrapping.
- R5: During fine trimming, `delayCode` starts at 64. At each window end it steps +1 if the phase just below `samplePhase` saw more transitions than the phase just above it, and −1 in the opposite case. It never changes by more than one per cycle.
- R6: Fine trimming freezes without taking a step in three cases: the two neighbour counts are equal, the wanted step reverses the previous step, or the step would pass 0 or 127. `locked` rises when it freezes.
- R7: While locked and without relock, `samplePhase` and `delayCode` stay constant whatever transitions arrive.
- R8: With no transitions, no window closes, so `locked`, `samplePhase` and `delayCode` keep their values.
- R9: While locked, `pixOut` takes the `pixIn` sampled on the edge whose phase equals `samplePhase`, and `pixValid` is high for the one cycle after that edge. While unlocked, `pixValid` stays low.
- R10: One cycle of `relock` clears all counters and drops `locked`. It returns `delayCode` to 64 and `samplePhase` to 0 on the next edge, and acquisition restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, PHASES times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| relock | input | 1 | Synchronous request to discard the lock and reacquire |
| pixIn | input | 12 | Unclocked colour word, 4 bits per channel |
| pixOut | output | 12 | Resampled colour word |
| pixValid | output | 1 | One-cycle strobe marking a new `pixOut` |
| locked | output | 1 | Coarse and fine selections are both frozen |
| delayCode | output | 7 | Binary tap select for the external delay line |
| samplePhase | output | 2 | Chosen sub-pixel sampling phase |

## Verification
The first pattern puts single-bit changes that walk across all twelve bits onto one phase. It shows whether every bit feeds the transition detector and whether the half-pixel offset is applied. A window one transition short is checked as well, to confirm the exact window length. The second pattern is a delay-line model that moves edges from the early neighbour to the late one once the code passes a threshold. This tells a lock-on-reversal apart from a lock on the limit. A third pattern splits all-bit toggles evenly across two phases, which exercises the tie rule and the equal-neighbour freeze. A fourth pattern keeps the early neighbour busy without end, which drives the code to its upper limit. A scoreboard of distinct words, changed mid-pixel while locked, confirms that capture happens on the chosen phase.

// File: rtl/pprPkg.sv
package pprPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clrCnt;   // clear all transition counters this edge
    logic outEn;    // resample pixels on the chosen phase
  } pprStrobe_t;

  typedef enum logic [1:0] {
    ST_ACQ  = 2'd0,
    ST_FINE = 2'd1,
    ST_LOCK = 2'd2
  } pprState_t;
endpackage

// File: rtl/pprDatapath.sv
module pprDatapath
  import pprPkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int PHASES    = 4,
  parameter int CNT_W     = 12,
  parameter int ACQ_TOTAL = 4096,
  localparam int PH_W     = $clog2(PHASES),
  localparam int TOT_W    = $clog2(ACQ_TOTAL + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [DATA_W-1:0]             pixIn,
  input  pprStrobe_t                    strb,
  input  logic [PH_W-1:0]               samplePh,
  output logic [PHASES-1:0][CNT_W-1:0]  cntAll,
  output logic                          winDone,
  output logic [DATA_W-1:0]             pixOut,
  output logic                          pixValid
);

  localparam logic [TOT_W-1:0] TOT_LIM = TOT_W'(ACQ_TOTAL);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(PHASES - 1);

  logic [PH_W-1:0]   phaseCnt;
  logic [DATA_W-1:0] prevPix;
  logic              trans;
  logic              countEn;
  logic [TOT_W-1:0]  totCnt;
  logic [CNT_W-1:0]  cntR [PHASES];
  logic [PHASES-1:0] hit;

  // Local pixel-rate divider: labels each edge with a sub-pixel phase
  always_ff @(posedge clk) begin
    if (rst)                   phaseCnt <= '0;
    else if (phaseCnt == PH_LAST) phaseCnt <= '0;
    else                       phaseCnt <= phaseCnt + 1'b1;
  end

  // Transition detector over every colour bit
  always_ff @(posedge clk) begin
    if (rst) prevPix <= '0;
    else     prevPix <= pixIn;
  end

  assign trans   = |(pixIn ^ prevPix);
  assign winDone = (totCnt == TOT_LIM);
  assign countEn = trans && !winDone;

  genvar g;
  generate
    for (g = 0; g < PHASES; g++) begin : g_hit
      assign hit[g]    = countEn && (phaseCnt == PH_W'(g));
      assign cntAll[g] = cntR[g];
    end
  endgenerate

  // Per-phase saturating transition counters
  always_ff @(posedge clk) begin
    for (int i = 0; i < PHASES; i++) begin
      if (rst || strb.clrCnt)             cntR[i] <= '0;
      else if (hit[i] && cntR[i] != CNT_MAX) cntR[i] <= cntR[i] + 1'b1;
    end
  end

  // Window length counter
  always_ff @(posedge clk) begin
    if (rst || strb.clrCnt) totCnt <= '0;
    else if (countEn)       totCnt <= totCnt + 1'b1;
  end

  // Output resampling register
  always_ff @(posedge clk) begin
    if (rst) begin
      pixOut   <= '0;
      pixValid <= 1'b0;
    end else begin
      pixValid <= strb.outEn && (phaseCnt == samplePh);
      if (strb.outEn && (phaseCnt == samplePh)) pixOut <= pixIn;
    end
  end

  AST_TOTAL_BOUND: assert property (@(posedge clk) disable iff (rst)
    totCnt <= TOT_LIM); // R4
  AST_VALID_ON_PHASE: assert property (@(posedge clk) disable iff (rst)
    pixValid |-> ($past(phaseCnt) == $past(samplePh))); // R9
  AST_CLEAR_WINDOW: assert property (@(posedge clk) disable iff (rst)
    strb.clrCnt |=> (totCnt == '0)); // R10
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (cntR[0] == CNT_MAX && !strb.clrCnt) |=> (cntR[0] == CNT_MAX)); // R4

endmodule

// File: rtl/pprControl.sv
module pprControl
  import pprPkg::*;
#(
  parameter int PHASES = 4,
  parameter int CNT_W  = 12,
  parameter int CODE_W = 7,
  localparam int PH_W  = $clog2(PHASES),
  localparam int HALF  = PHASES / 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          relock,
  input  logic [PHASES-1:0][CNT_W-1:0]  cntAll,
  input  logic                          winDone,
  output pprStrobe_t                    strb,
  output logic [PH_W-1:0]               samplePh,
  output logic [CODE_W-1:0]             delayCode,
  output logic                          locked
);

  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1 << (CODE_W - 1));
  localparam logic [CODE_W-1:0] CODE_TOP = {CODE_W{1'b1}};

  pprState_t         state;
  logic              lastUp;
  logic              lastValid;
  logic [CNT_W-1:0]  best;
  logic [PH_W-1:0]   bestIdx;
  logic [PH_W-1:0]   pick;
  logic [CNT_W-1:0]  earlyCnt;
  logic [CNT_W-1:0]  lateCnt;
  logic              wantUp;
  int                pickI;
  int                earlyI;
  int                lateI;

  // Busiest phase, lowest index on ties
  always_comb begin
    best    = cntAll[0];
    bestIdx = '0;
    for (int i = 1; i < PHASES; i++) begin
      if (cntAll[i] > best) begin
        best    = cntAll[i];
        bestIdx = PH_W'(i);
      end
    end
    pickI = int'(bestIdx) + HALF;
    if (pickI >= PHASES) pickI = pickI - PHASES;
    pick = PH_W'(pickI);
  end

  // Neighbour phases around the chosen sampling phase
  always_comb begin
    earlyI = int'(samplePh) - 1;
    if (earlyI < 0) earlyI = earlyI + PHASES;
    lateI = int'(samplePh) + 1;
    if (lateI >= PHASES) lateI = lateI - PHASES;
    earlyCnt = cntAll[earlyI];
    lateCnt  = cntAll[lateI];
    wantUp   = (earlyCnt > lateCnt);
  end

  always_comb begin
    strb.clrCnt = relock || (winDone && state != ST_LOCK);
    strb.outEn  = (state == ST_LOCK) && !relock;
  end

  assign locked = (state == ST_LOCK);

  always_ff @(posedge clk) begin
    if (rst || relock) begin
      state     <= ST_ACQ;
      samplePh  <= '0;
      delayCode <= CODE_MID;
      lastUp    <= 1'b0;
      lastValid <= 1'b0;
    end else begin
      case (state)
        ST_ACQ: begin
          if (winDone) begin
            samplePh <= pick;
            state    <= ST_FINE;
          end
        end
        ST_FINE: begin
          if (winDone) begin
            if (earlyCnt == lateCnt)                 state <= ST_LOCK;
            else if (lastValid && lastUp != wantUp)  state <= ST_LOCK;
            else if (wantUp && delayCode == CODE_TOP) state <= ST_LOCK;
            else if (!wantUp && delayCode == '0)     state <= ST_LOCK;
            else begin
              delayCode <= wantUp ? delayCode + 1'b1 : delayCode - 1'b1;
              lastUp    <= wantUp;
              lastValid <= 1'b1;
            end
          end
        end
        default: state <= ST_LOCK;
      endcase
    end
  end

  AST_CODE_STEP: assert property (@(posedge clk) disable iff (rst)
    !relock |=> (delayCode == $past(delayCode) ||
                 delayCode == $past(delayCode) + 1'b1 ||
                 delayCode == $past(delayCode) - 1'b1)); // R5
  AST_ACQ_MID: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACQ) |-> (delayCode == CODE_MID)); // R5
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (locked && !relock) |=> (locked && $stable(delayCode) && $stable(samplePh))); // R7
  AST_RELOCK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    relock |=> (!locked && delayCode == CODE_MID && samplePh == '0)); // R10

endmodule

// File: rtl/pixelPhaseRecover.sv
module pixelPhaseRecover
  import pprPkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int PHASES    = 4,
  parameter int CNT_W     = 12,
  parameter int ACQ_TOTAL = 4096,
  parameter int CODE_W    = 7
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       relock,
  input  logic [DATA_W-1:0]          pixIn,
  output logic [DATA_W-1:0]          pixOut,
  output logic                       pixValid,
  output logic                       locked,
  output logic [CODE_W-1:0]          delayCode,
  output logic [$clog2(PHASES)-1:0]  samplePhase
);

  pprStrobe_t                   strb;
  logic [PHASES-1:0][CNT_W-1:0] cntAll;
  logic                         winDone;

  pprDatapath #(
    .DATA_W(DATA_W), .PHASES(PHASES), .CNT_W(CNT_W), .ACQ_TOTAL(ACQ_TOTAL)
  ) u_dp (
    .clk(clk), .rst(rst), .pixIn(pixIn), .strb(strb), .samplePh(samplePhase),
    .cntAll(cntAll), .winDone(winDone), .pixOut(pixOut), .pixValid(pixValid)
  );

  pprControl #(
    .PHASES(PHASES), .CNT_W(CNT_W), .CODE_W(CODE_W)
  ) u_ctl (
    .clk(clk), .rst(rst), .relock(relock), .cntAll(cntAll), .winDone(winDone),
    .strb(strb), .samplePh(samplePhase), .delayCode(delayCode), .locked(locked)
  );

  AST_UNLOCKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    pixValid |-> $past(locked)); // R9

endmodule

// File: tb/pixelPhaseRecover_tb.sv
module pixelPhaseRecover_tb;
  localparam int WIN = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        relock = 1'b0;
  logic [11:0] pixIn = '0;
  logic [11:0] pixOut;
  logic        pixValid;
  logic        locked;
  logic [6:0]  delayCode;
  logic [1:0]  samplePhase;

  int nChecks = 0;
  int nFails  = 0;
  int nPopped = 0;
  logic [1:0]  benchPh = '0;
  logic        scoreOn = 1'b0;
  logic [11:0] expQ[$];

  always #2.5 clk = ~clk;

  pixelPhaseRecover #(.ACQ_TOTAL(WIN)) u_dut (
    .clk(clk), .rst(rst), .relock(relock), .pixIn(pixIn), .pixOut(pixOut),
    .pixValid(pixValid), .locked(locked), .delayCode(delayCode),
    .samplePhase(samplePhase)
  );

  // Independent phase label of the next rising edge
  always @(posedge clk) begin
    if (rst) benchPh <= '0;
    else     benchPh <= benchPh + 2'd1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Toggle the masked bits so the change is first sampled on phase ph
  task automatic transAt(input int ph, input logic [11:0] mask);
    @(negedge clk);
    while (int'(benchPh) != ph) @(negedge clk);
    pixIn = pixIn ^ mask;
  endtask

  task automatic pulseRelock();
    @(negedge clk);
    relock = 1'b1;
    @(negedge clk);
    relock = 1'b0;
  endtask

  // Monitor side of the scoreboard
  always @(negedge clk) begin
    if (scoreOn && pixValid) begin
      nChecks++;
      if (expQ.size() == 0) begin
        nFails++;
        $display("FAIL R9: actual %0d expected none", pixOut);
      end else begin
        logic [11:0] e;
        e = expQ.pop_front();
        nPopped++;
        if (pixOut !== e) begin
          nFails++;
          $display("FAIL R9: actual %0d expected %0d", pixOut, e);
        end
      end
    end
  end

  initial begin
    #500000;
    nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(!locked && !pixValid && delayCode == 7'd64 && samplePhase == 2'd0,
          "R1", {locked, pixValid, delayCode, samplePhase}, 7'd64 << 2);

    // R8 idle: no transitions, nothing moves
    repeat (200) @(negedge clk);
    check(!locked && delayCode == 7'd64 && samplePhase == 2'd0, "R8",
          {locked, delayCode, samplePhase}, 7'd64 << 2);

    // R2/R4: single-bit changes across every bit on phase 1, one short of a window
    for (int k = 0; k < WIN - 1; k++) transAt(1, 12'(1 << (k % 12)));
    repeat (20) @(negedge clk);
    check(samplePhase == 2'd0 && !locked, "R4", samplePhase, 0);
    transAt(1, 12'h080);
    repeat (2) @(negedge clk);
    check(samplePhase == 2'd3, "R2 R3", samplePhase, 3);
    check(delayCode == 7'd64 && !locked, "R5", delayCode, 64);

    // Delay-line model: early edges (phase 2) until code reaches 67, then late (phase 0)
    for (int i = 0; i < 2000 && !locked; i++)
      transAt((delayCode < 7'd67) ? 2 : 0, 12'(1 << (i % 12)));
    @(negedge clk);
    check(locked, "R6", locked, 1);
    check(delayCode == 7'd67, "R5 R6", delayCode, 67);
    check(samplePhase == 2'd3, "R3", samplePhase, 3);

    // R9 scoreboard: new word mid-pixel (phase 1), sampled on phase 3
    @(negedge clk);
    while (benchPh != 2'd1) @(negedge clk);
    scoreOn = 1'b1;
    for (int n = 0; n < 24; n++) begin
      logic [11:0] v;
      v = 12'(n * 173 + 5);
      while (benchPh != 2'd1) @(negedge clk);
      pixIn = v;
      expQ.push_back(v);
      @(negedge clk);
    end
    for (int t = 0; t < 40 && expQ.size() != 0; t++) @(posedge clk);
    scoreOn = 1'b0;
    check(nPopped == 24, "R9", nPopped, 24);

    // R7: traffic during lock left everything frozen
    check(locked && delayCode == 7'd67 && samplePhase == 2'd3, "R7",
          delayCode, 67);

    // R10 relock
    pulseRelock();
    check(!locked && delayCode == 7'd64 && samplePhase == 2'd0, "R10",
          {locked, delayCode, samplePhase}, 7'd64 << 2);
    repeat (6) @(negedge clk);
    check(!pixValid, "R9", pixValid, 0);

    // Tie: all-bit toggles split evenly over phases 0 and 2
    for (int k = 0; k < WIN; k++) transAt((k % 2 == 0) ? 0 : 2, 12'hFFF);
    repeat (3) @(negedge clk);
    check(samplePhase == 2'd2, "R3", samplePhase, 2);
    repeat (300) @(negedge clk);
    check(!locked && delayCode == 7'd64 && samplePhase == 2'd2, "R8",
          {locked, delayCode}, 64);
    for (int i = 0; i < 400 && !locked; i++) transAt((i % 2 == 0) ? 0 : 2, 12'hFFF);
    @(negedge clk);
    check(locked && delayCode == 7'd64, "R6", delayCode, 64);

    // Limit: early neighbour busy forever drives the code to the top
    pulseRelock();
    for (int k = 0; k < WIN; k++) transAt(3, 12'h800);
    repeat (3) @(negedge clk);
    check(samplePhase == 2'd1, "R3", samplePhase, 1);
    for (int i = 0; i < 3000 && !locked; i++) transAt(0, 12'(1 << (i % 12)));
    @(negedge clk);
    check(locked && delayCode == 7'd127, "R6", delayCode, 127);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule